// File: doc/BRIEF.md
# Minimum-Phase PI Duty Regulator

This block closes the inner current loop of a three-leg shunt compensator. On each sample strobe it takes, for every phase, a current reference, a measured filter current and a feedforward voltage. It forms the current error and runs it through a proportional-plus-integral law. It adds the feedforward term to get a pole-voltage command and divides that command by the clamp-capacitor voltage. The result is an unsigned duty ratio that is ready for a carrier comparator.

The legs are tied to whichever supply phase is currently lowest, and a per-phase flag marks that phase. For the flagged phase the integrator keeps its stored value rather than integrating an error it cannot act on. That leg is also not modulated: its enable is dropped, which holds the lower switch on and the upper switch off, and its duty reads zero. Only two legs switch at any time. When the flag moves to another phase, the integrator of the released phase continues from the value it held.

The block is sized for a sample rate near 10 kHz, with the current loop an order of magnitude slower. A result takes 18 clock cycles, far inside one sample period at any practical fabric clock. The division is done sequentially, one quotient bit per cycle, in one divider per phase.

Top module: `mpc_ctrl`

## Requirements
- R1: For each phase the error is reference minus measured current. The proportional term is (kp*err)>>>12, and the integrator adds (ki*err)>>>12 each sample. Gains are signed Q4.12, and arithmetic shifts round toward minus infinity.
- R2: The command is proportional term plus integrator plus feedforward. The duty is floor(command*32768/clamp), written as unsigned Q1.15 where 0x8000 means 1.0.
- R3: A command of zero or less gives duty 0, and a command at or above the clamp voltage gives duty 0x8000.
- R4: A clamp voltage of zero gives duty 0 on every leg.
- R5: While bit p of `min_flag` is set (bit 0 is phase a), the integrator of phase p keeps its value across the sample.
- R6: The flagged leg outputs `leg_en[p]=0` (lower switch held on) with duty 0. Every unflagged leg has `leg_en=1`.
- R7: After the flag clears, the integrator resumes from its held value, with no reset.
- R8: An updated integrator is limited to the range [`int_lo`, `int_hi`].
- R9: Outputs and a one-cycle `done` pulse appear 18 cycles after the edge that samples the strobe. Outputs hold between results, and a strobe that arrives while a result is pending is ignored.
- R10: Reset clears the duties, leg enables, `done` and all integrators to zero.
- R11: All inputs are sampled only at the edge that accepts the strobe. Later changes do not affect that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp | input | 1 | Sample strobe |
| i_ref | input | 3x16 | Signed current references, per phase |
| i_meas | input | 3x16 | Signed measured filter currents |
| v_ff | input | 3x16 | Signed feedforward voltages |
| kp | input | 16 | Proportional gain, signed Q4.12 |
| ki | input | 16 | Integral gain, signed Q4.12 |
| int_lo | input | 24 | Signed lower integrator limit |
| int_hi | input | 24 | Signed upper integrator limit |
| v_clamp | input | 16 | Unsigned clamp-capacitor voltage |
| min_flag | input | 3 | One-hot-or-zero lowest-phase flag |
| duty | output | 3x16 | Unsigned Q1.15 duty ratios |
| leg_en | output | 3 | Leg modulation enable, 0 holds the lower switch on |
| done | output | 1 | One-cycle result strobe |

## Verification
The strobe is accepted at one edge, and the new duties, enables and `done` appear 18 edges later. The bench therefore waits exactly that many falling edges after it releases the strobe. It checks that `done` is still low one cycle early, reads the result on the 18th falling edge, and confirms one cycle later that `done` has fallen and the outputs are unchanged. Right after each strobe it overwrites every input with unrelated values, so a design that samples late produces wrong duties. A further strobe is placed in the middle of a computation, and the bench confirms that no extra result appears.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALC,
    ST_LOAD,
    ST_DIV,
    ST_OUT
  } mpc_state_e;
endpackage

// File: rtl/mpc_pi_lane.sv
module mpc_pi_lane #(
  parameter int DW    = 16,
  parameter int GW    = 16,
  parameter int IW    = 24,
  parameter int CW    = 26,
  parameter int GFRAC = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap,
  input  logic                 calc,
  input  logic                 frz,
  input  logic signed [DW-1:0] ref_i,
  input  logic signed [DW-1:0] meas_i,
  input  logic signed [DW-1:0] ff_i,
  input  logic signed [GW-1:0] kp_i,
  input  logic signed [GW-1:0] ki_i,
  input  logic signed [IW-1:0] lo_i,
  input  logic signed [IW-1:0] hi_i,
  output logic signed [IW-1:0] integ_o,
  output logic signed [CW-1:0] cmd_o
);
  localparam int EW = DW + 1;
  localparam int PW = EW + GW;
  localparam int SW = PW + 2;
  localparam logic signed [SW-1:0] CMAX = SW'((64'sd1 <<< (CW - 1)) - 64'sd1);
  localparam logic signed [SW-1:0] CMIN = -CMAX - SW'(1);

  logic signed [EW-1:0] err_q;
  logic signed [DW-1:0] ff_q;
  logic signed [PW-1:0] p_prod, i_prod;
  logic signed [SW-1:0] i_sum, c_sum;
  logic signed [IW-1:0] i_new;
  logic signed [CW-1:0] c_sat;

  always_comb begin
    p_prod = kp_i * err_q;
    i_prod = ki_i * err_q;
    i_sum  = SW'(integ_o) + SW'(i_prod >>> GFRAC);
    if (frz)                     i_new = integ_o;
    else if (i_sum > SW'(hi_i))  i_new = hi_i;
    else if (i_sum < SW'(lo_i))  i_new = lo_i;
    else                         i_new = IW'(i_sum);
    c_sum = SW'(p_prod >>> GFRAC) + SW'(i_new) + SW'(ff_q);
    if (c_sum > CMAX)            c_sat = CW'(CMAX);
    else if (c_sum < CMIN)       c_sat = CW'(CMIN);
    else                         c_sat = CW'(c_sum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q   <= '0;
      ff_q    <= '0;
      integ_o <= '0;
      cmd_o   <= '0;
    end else begin
      if (cap) begin
        err_q <= EW'(ref_i) - EW'(meas_i);
        ff_q  <= ff_i;
      end
      if (calc) begin
        integ_o <= i_new;
        cmd_o   <= c_sat;
      end
    end
  end
endmodule

// File: rtl/mpc_div.sv
module mpc_div #(
  parameter int DW   = 16,
  parameter int CW   = 26,
  parameter int FRAC = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 step,
  input  logic signed [CW-1:0] cmd_i,
  input  logic        [DW-1:0] vcl_i,
  output logic        [FRAC:0] duty_o
);
  logic [DW-1:0]   rem;
  logic [FRAC-1:0] quot;
  logic            zero_q, full_q;
  logic [DW:0]     sh;
  logic            ge;

  always_comb begin
    sh = {rem, 1'b0};
    ge = (sh >= {1'b0, vcl_i});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem    <= '0;
      quot   <= '0;
      zero_q <= 1'b1;
      full_q <= 1'b0;
    end else if (load) begin
      zero_q <= (vcl_i == '0) || (cmd_i <= 0);
      full_q <= cmd_i >= $signed({{(CW - DW){1'b0}}, vcl_i});
      rem    <= DW'(cmd_i);
      quot   <= '0;
    end else if (step) begin
      rem  <= ge ? DW'(sh - {1'b0, vcl_i}) : DW'(sh);
      quot <= {quot[FRAC-2:0], ge};
    end
  end

  always_comb begin
    if (zero_q)      duty_o = '0;
    else if (full_q) duty_o = {1'b1, {FRAC{1'b0}}};
    else             duty_o = {1'b0, quot};
  end
endmodule

// File: rtl/mpc_ctrl.sv
module mpc_ctrl #(
  parameter int NPH   = 3,
  parameter int DW    = 16,
  parameter int GW    = 16,
  parameter int IW    = 24,
  parameter int GFRAC = 12,
  parameter int FRAC  = 15
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         smp,
  input  logic [NPH-1:0][DW-1:0]       i_ref,
  input  logic [NPH-1:0][DW-1:0]       i_meas,
  input  logic [NPH-1:0][DW-1:0]       v_ff,
  input  logic [GW-1:0]                kp,
  input  logic [GW-1:0]                ki,
  input  logic [IW-1:0]                int_lo,
  input  logic [IW-1:0]                int_hi,
  input  logic [DW-1:0]                v_clamp,
  input  logic [NPH-1:0]               min_flag,
  output logic [NPH-1:0][FRAC:0]       duty,
  output logic [NPH-1:0]               leg_en,
  output logic                         done
);
  import mpc_pkg::*;
  localparam int CW   = IW + 2;
  localparam int CNTW = $clog2(FRAC + 1);

  mpc_state_e          st;
  logic [CNTW-1:0]     cnt;
  logic                cap, calc, load, step;
  logic [GW-1:0]       kp_q, ki_q;
  logic [IW-1:0]       lo_q, hi_q;
  logic [DW-1:0]       vcl_q;
  logic [NPH-1:0]      min_q;
  logic [NPH-1:0][IW-1:0] integ_all;
  logic [NPH-1:0][CW-1:0] cmd_all;
  logic [NPH-1:0][FRAC:0] div_duty;

  assign cap  = (st == ST_IDLE) && smp;
  assign calc = (st == ST_CALC);
  assign load = (st == ST_LOAD);
  assign step = (st == ST_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      kp_q   <= '0;
      ki_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      vcl_q  <= '0;
      min_q  <= '0;
      duty   <= '0;
      leg_en <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (smp) begin
          kp_q  <= kp;
          ki_q  <= ki;
          lo_q  <= int_lo;
          hi_q  <= int_hi;
          vcl_q <= v_clamp;
          min_q <= min_flag;
          st    <= ST_CALC;
        end
        ST_CALC: st <= ST_LOAD;
        ST_LOAD: begin
          cnt <= '0;
          st  <= ST_DIV;
        end
        ST_DIV: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNTW'(FRAC - 1)) st <= ST_OUT;
        end
        ST_OUT: begin
          for (int p = 0; p < NPH; p++) begin
            duty[p]   <= min_q[p] ? '0 : div_duty[p];
            leg_en[p] <= ~min_q[p];
          end
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    mpc_pi_lane #(.DW(DW), .GW(GW), .IW(IW), .CW(CW), .GFRAC(GFRAC)) u_lane (
      .clk(clk), .rst(rst), .cap(cap), .calc(calc), .frz(min_q[g]),
      .ref_i(i_ref[g]), .meas_i(i_meas[g]), .ff_i(v_ff[g]),
      .kp_i(kp_q), .ki_i(ki_q), .lo_i(lo_q), .hi_i(hi_q),
      .integ_o(integ_all[g]), .cmd_o(cmd_all[g])
    );
    mpc_div #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_div (
      .clk(clk), .rst(rst), .load(load), .step(step),
      .cmd_i(cmd_all[g]), .vcl_i(vcl_q), .duty_o(div_duty[g])
    );
  end
endmodule

// File: rtl/mpc_ctrl_chk.sv
module mpc_ctrl_chk #(
  parameter int NPH  = 3,
  parameter int DW   = 16,
  parameter int IW   = 24,
  parameter int FRAC = 15
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   done,
  input logic [NPH-1:0]         leg_en,
  input logic [NPH-1:0][FRAC:0] duty,
  input logic                   calc,
  input logic [NPH-1:0]         min_q,
  input logic [DW-1:0]          vcl_q,
  input logic [NPH-1:0][IW-1:0] integ_all,
  input logic [IW-1:0]          lo_q,
  input logic [IW-1:0]          hi_q
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(duty) && $stable(leg_en)));

  for (genvar p = 0; p < NPH; p++) begin : g_chk
    // R3
    duty_range_chk: assert property (@(posedge clk) disable iff (rst)
      duty[p] <= (FRAC + 1)'(1 << FRAC));
    // R6
    idle_leg_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (done && !leg_en[p]) |-> (duty[p] == '0));
    // R4
    zero_clamp_chk: assert property (@(posedge clk) disable iff (rst)
      (done && (vcl_q == '0)) |-> (duty[p] == '0));
    // R5
    frozen_integ_chk: assert property (@(posedge clk) disable iff (rst)
      (calc && min_q[p]) |=> $stable(integ_all[p]));
    // R8
    integ_limit_chk: assert property (@(posedge clk) disable iff (rst)
      (calc && !min_q[p]) |=>
        ($signed(integ_all[p]) <= $signed(hi_q) && $signed(integ_all[p]) >= $signed(lo_q)));
  end
endmodule

bind mpc_ctrl mpc_ctrl_chk #(.NPH(NPH), .DW(DW), .IW(IW), .FRAC(FRAC)) u_chk (
  .clk(clk), .rst(rst), .done(done), .leg_en(leg_en), .duty(duty),
  .calc(calc), .min_q(min_q), .vcl_q(vcl_q), .integ_all(integ_all),
  .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/mpc_ctrl_test.sv
module mpc_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp = 1'b0;
  logic [2:0][15:0] i_ref, i_meas, v_ff;
  logic [15:0] kp, ki, v_clamp;
  logic [23:0] int_lo, int_hi;
  logic [2:0]  min_flag;
  logic [2:0][15:0] duty;
  logic [2:0]  leg_en;
  logic        done;
  int checks = 0;
  int errors = 0;
  longint im [3];

  always #4 clk = ~clk;

  mpc_ctrl uut (
    .clk(clk), .rst(rst), .smp(smp), .i_ref(i_ref), .i_meas(i_meas), .v_ff(v_ff),
    .kp(kp), .ki(ki), .int_lo(int_lo), .int_hi(int_hi), .v_clamp(v_clamp),
    .min_flag(min_flag), .duty(duty), .leg_en(leg_en), .done(done)
  );

  typedef struct packed {
    logic signed [15:0] r0, r1, r2, m0, m1, m2, f0, f1, f2, kp, ki;
    logic [15:0] vc;
    logic [2:0]  mn;
    logic signed [23:0] lo, hi;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{16'sd300, -16'sd200, 16'sd100, 16'sd100, -16'sd100, 16'sd0, 16'sd500, 16'sd800, 16'sd1500,
      16'sd4096, 16'sd2048, 16'd4000, 3'b000, -24'sd200000, 24'sd200000},
    '{16'sd50, 16'sd60, 16'sd70, 16'sd10, 16'sd20, 16'sd30, 16'sd1000, 16'sd1200, 16'sd1400,
      16'sd8192, 16'sd1024, 16'd3000, 3'b100, -24'sd200000, 24'sd200000},
    '{16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd0, 16'sd5000, -16'sd3000, 16'sd2500,
      16'sd4096, 16'sd0, 16'd2000, 3'b000, -24'sd200000, 24'sd200000},
    '{16'sd1000, 16'sd10, 16'sd10, 16'sd0, 16'sd0, 16'sd0, 16'sd100, 16'sd900, 16'sd900,
      16'sd4096, 16'sd4096, 16'd5000, 3'b001, -24'sd200000, 24'sd200000},
    '{16'sd1000, 16'sd10, 16'sd10, 16'sd0, 16'sd0, 16'sd0, 16'sd100, 16'sd900, 16'sd900,
      16'sd4096, 16'sd4096, 16'd5000, 3'b001, -24'sd200000, 24'sd200000},
    '{16'sd100, 16'sd10, 16'sd10, 16'sd0, 16'sd0, 16'sd0, 16'sd100, 16'sd900, 16'sd900,
      16'sd4096, 16'sd4096, 16'd5000, 3'b000, -24'sd200000, 24'sd200000},
    '{16'sd2000, 16'sd2000, -16'sd2000, 16'sd0, 16'sd0, 16'sd0, 16'sd400, 16'sd400, 16'sd400,
      16'sd4096, 16'sd4096, 16'd6000, 3'b100, -24'sd150, 24'sd150},
    '{16'sd100, 16'sd100, 16'sd100, 16'sd0, 16'sd0, 16'sd0, 16'sd500, 16'sd500, 16'sd500,
      16'sd4096, 16'sd4096, 16'd0, 3'b000, -24'sd200000, 24'sd200000},
    '{-16'sd400, 16'sd300, 16'sd50, 16'sd100, -16'sd100, 16'sd25, 16'sd2500, 16'sd2500, 16'sd2500,
      -16'sd4096, -16'sd2048, 16'd8000, 3'b010, -24'sd200000, 24'sd200000}
  };
  localparam string TAG [NV] = '{"R1", "R11", "R3", "R5", "R5", "R7", "R8", "R4", "R2"};

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic scramble();
    for (int p = 0; p < 3; p++) begin
      i_ref[p]  = 16'h7fff;
      i_meas[p] = 16'h8000;
      v_ff[p]   = 16'h7fff;
    end
    kp = 16'h0;
    ki = 16'h7fff;
    v_clamp = 16'd1;
    min_flag = 3'b111;
    int_lo = 24'h0;
    int_hi = 24'h0;
  endtask

  task automatic run(vec_t v, string tag, bit busy);
    longint r [3];
    longint m [3];
    longint f [3];
    longint e, s, cmd, ed;
    logic [2:0][15:0] held;
    int extra;
    r = '{v.r0, v.r1, v.r2};
    m = '{v.m0, v.m1, v.m2};
    f = '{v.f0, v.f1, v.f2};
    for (int p = 0; p < 3; p++) begin
      i_ref[p]  = 16'(r[p]);
      i_meas[p] = 16'(m[p]);
      v_ff[p]   = 16'(f[p]);
    end
    kp = v.kp; ki = v.ki; v_clamp = v.vc; min_flag = v.mn;
    int_lo = v.lo; int_hi = v.hi;
    smp = 1'b1;
    @(negedge clk);
    smp = 1'b0;
    scramble();
    for (int k = 1; k <= 17; k++) begin
      @(negedge clk);
      smp = (busy && k == 5);
    end
    chk("R9", "done early", longint'(done), 0);
    @(negedge clk);
    chk("R9", "done due", longint'(done), 1);
    for (int p = 0; p < 3; p++) begin
      e = r[p] - m[p];
      if (!v.mn[p]) begin
        s = im[p] + ((longint'(v.ki) * e) >>> 12);
        if (s > longint'(v.hi)) s = v.hi;
        if (s < longint'(v.lo)) s = v.lo;
        im[p] = s;
      end
      cmd = ((longint'(v.kp) * e) >>> 12) + im[p] + f[p];
      if (v.mn[p] || v.vc == 0 || cmd <= 0) ed = 0;
      else if (cmd >= longint'(v.vc)) ed = 32768;
      else ed = (cmd * 32768) / longint'(v.vc);
      chk(tag, $sformatf("duty[%0d]", p), longint'(duty[p]), ed);
      chk("R6", $sformatf("leg_en[%0d]", p), longint'(leg_en[p]), v.mn[p] ? 0 : 1);
    end
    held = duty;
    @(negedge clk);
    chk("R9", "done falls", longint'(done), 0);
    chk("R9", "duty held", longint'(duty == held), 1);
    if (busy) begin
      extra = 0;
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R9", "strobe while busy ignored", extra, 0);
    end
  endtask

  initial begin
    for (int p = 0; p < 3; p++) im[p] = 0;
    scramble();
    repeat (4) @(negedge clk);
    chk("R10", "reset duty", longint'(duty), 0);
    chk("R10", "reset leg_en", longint'(leg_en), 0);
    chk("R10", "reset done", longint'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run(VEC[i], TAG[i], 1'b0);
    run(VEC[0], "R9", 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule